// File: doc/BRIEF.md
# Branch Hazard Fetch Controller

This block owns the program counter and the fetch-control signals of a five-stage in-order pipeline. Each cycle it looks at the instruction word sitting in the decode stage and the two register operands read for it. It decides branch-if-equal instructions, computes their targets and produces the next fetch address. It tells the fetch stage when to hold, and it replaces any wrong-path word in decode with a harmless bubble before that word reaches execute.

A parameter selects one of two resolution schemes. In the early scheme, a dedicated comparator in decode settles the branch in the same cycle that the opcode is recognised, so a taken branch loses only the one word that was already fetched behind it. In the baseline scheme, the operands are carried into the execute stage and compared there. Fetch is held for two cycles on every branch, taken or not, so each branch occupies three cycles. The surrounding pipeline keeps its decode register unchanged while `fetch_hold` is high and otherwise loads the word fetched from `fetch_pc`.

Top module: `branch_fetch_ctrl`

## Requirements
- R1: On a synchronous active-high reset, `fetch_pc` becomes 0, and any pending bubble or stall is cleared. In the first cycle after reset, `dec_squash` and `fetch_hold` are low while decode holds a non-branch word.
- R2: Only opcode 6'b000100 in bits 31:26 is a conditional branch. With no hold and no redirect, `fetch_pc` advances by 4 every cycle. Any other opcode, such as 6'b000101 with equal operands, never redirects, holds or squashes.
- R3: The branch target is the decode-stage instruction's address plus 4, plus bits 15:0 sign-extended and shifted left by 2. The branch is taken when `dec_rs_val` equals `dec_rt_val`.
- R4: Early scheme, taken branch: `fetch_pc` equals the target in the next cycle, and `fetch_hold` stays low. The next cycle issues exactly one bubble, after which the word at the target is issued.
- R5: Early scheme, branch not taken: no bubble is issued, and the word after the branch is issued unchanged with the PC stepping by 4.
- R6: Baseline scheme: `fetch_hold` is high in the cycle the branch is in decode and in the cycle after. Two bubbles follow the branch, taken or not. The next real word is issued three cycles after the branch.
- R7: Baseline scheme: the comparison uses the operands captured when the branch left decode. Two cycles after the branch is in decode, `fetch_pc` is the target when taken and the branch address plus 4 when not.
- R8: A bubble is issued as an all-zero word with `iss_reg_we` and `iss_mem_we` both low.
- R9: The branch itself is issued with both write enables low. Store opcode 6'b101011 is issued with only `iss_mem_we` high. Every other opcode is issued with only `iss_reg_we` high.
- R10: A word in a squashed decode slot is never treated as a branch. A branch opcode there with equal operands does not move the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_instr | input | 32 | Instruction word currently in decode |
| dec_rs_val | input | XLEN | First register operand of the decode word |
| dec_rt_val | input | XLEN | Second register operand of the decode word |
| fetch_pc | output | XLEN | Address fetched this cycle |
| fetch_hold | output | 1 | Decode register must keep its word |
| dec_squash | output | 1 | Decode slot is issued as a bubble |
| iss_instr | output | 32 | Word handed to execute |
| iss_reg_we | output | 1 | Register write enable for the issued word |
| iss_mem_we | output | 1 | Memory write enable for the issued word |

## Verification
A wrong bubble flag shows up in the cycle right after the branch decision. Either `iss_instr` carries a wrong-path address where zero was due, or a real word is lost. A corrupted decode-address register or stall state shows as a wrong `fetch_pc` in the cycle after the branch, or as a hold that lasts one or three cycles instead of two. The address checks use words whose immediate field equals their own fetch address, so any fetch slip appears at `iss_instr` one cycle later.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int IMM_W   = 16;
    localparam int STEP_B  = 4;

    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;

    typedef enum logic [1:0] {
        CLS_ALU    = 2'd0,
        CLS_STORE  = 2'd1,
        CLS_BRANCH = 2'd2
    } cls_t;

    typedef struct packed {
        logic reg_we;
        logic mem_we;
    } wen_t;

    localparam wen_t WEN_NONE = '{reg_we: 1'b0, mem_we: 1'b0};

    function automatic cls_t classify(input logic [OPC_W-1:0] opc);
        cls_t c;
        if (opc == OPC_BEQ)
            c = CLS_BRANCH;
        else if (opc == OPC_STORE)
            c = CLS_STORE;
        else
            c = CLS_ALU;
        return c;
    endfunction

    function automatic wen_t wen_of(input cls_t c);
        wen_t w;
        w = WEN_NONE;
        case (c)
            CLS_ALU:   w.reg_we = 1'b1;
            CLS_STORE: w.mem_we = 1'b1;
            default:   w = WEN_NONE;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/bfc_decode.sv
module bfc_decode
    import bfc_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic               squash,
    output logic               is_branch,
    output wen_t               wen,
    output logic [IMM_W-1:0]   imm,
    output logic [INSTR_W-1:0] issued
);
    localparam int OPC_LSB = INSTR_W - OPC_W;

    cls_t cls;

    always_comb begin
        cls       = classify(instr[INSTR_W-1:OPC_LSB]);
        // a squashed slot is dead: it decodes as nothing at all
        is_branch = (cls == CLS_BRANCH) && !squash;
        wen       = squash ? WEN_NONE : wen_of(cls);
        imm       = instr[IMM_W-1:0];
        issued    = squash ? '0 : instr;
    end
endmodule

// File: rtl/bfc_target.sv
module bfc_target
    import bfc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  br_pc,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  target
);
    localparam int EXT_W = XLEN - IMM_W - 2;
    localparam logic [XLEN-1:0] LINK_OFS = XLEN'(STEP_B);

    logic [XLEN-1:0] offset;

    always_comb begin
        offset = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        target = br_pc + LINK_OFS + offset;
    end
endmodule

// File: rtl/bfc_resolve.sv
module bfc_resolve #(
    parameter int XLEN  = 32,
    parameter bit EARLY = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            is_branch,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [XLEN-1:0] target,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc,
    output logic            hold,
    output logic            squash
);
    generate
        if (EARLY) begin : g_early
            logic sq_q;

            always_comb begin
                redirect    = is_branch && (opnd_a == opnd_b);
                redirect_pc = target;
                hold        = 1'b0;
                squash      = sq_q;
            end

            always_ff @(posedge clk) begin
                if (rst)
                    sq_q <= 1'b0;
                else
                    sq_q <= redirect;
            end
        end else begin : g_late
            typedef enum logic [1:0] {
                ST_IDLE  = 2'd0,
                ST_EXEC  = 2'd1,
                ST_DRAIN = 2'd2
            } st_t;

            st_t             st_q;
            logic [XLEN-1:0] a_q;
            logic [XLEN-1:0] b_q;
            logic [XLEN-1:0] tgt_q;

            always_comb begin
                hold        = (st_q == ST_EXEC) || ((st_q == ST_IDLE) && is_branch);
                squash      = (st_q != ST_IDLE);
                redirect    = (st_q == ST_EXEC) && (a_q == b_q);
                redirect_pc = tgt_q;
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q  <= ST_IDLE;
                    a_q   <= '0;
                    b_q   <= '0;
                    tgt_q <= '0;
                end else begin
                    case (st_q)
                        ST_IDLE: begin
                            if (is_branch) begin
                                st_q  <= ST_EXEC;
                                a_q   <= opnd_a;
                                b_q   <= opnd_b;
                                tgt_q <= target;
                            end
                        end
                        ST_EXEC:  st_q <= ST_DRAIN;
                        default:  st_q <= ST_IDLE;
                    endcase
                end
            end
        end
    endgenerate
endmodule

// File: rtl/branch_fetch_ctrl.sv
module branch_fetch_ctrl
    import bfc_pkg::*;
#(
    parameter int XLEN          = 32,
    parameter bit EARLY_RESOLVE = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] dec_instr,
    input  logic [XLEN-1:0]    dec_rs_val,
    input  logic [XLEN-1:0]    dec_rt_val,
    output logic [XLEN-1:0]    fetch_pc,
    output logic               fetch_hold,
    output logic               dec_squash,
    output logic [INSTR_W-1:0] iss_instr,
    output logic               iss_reg_we,
    output logic               iss_mem_we
);
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(STEP_B);

    logic [XLEN-1:0]  pc_q;
    logic [XLEN-1:0]  dec_pc_q;
    logic [XLEN-1:0]  target;
    logic [XLEN-1:0]  redirect_pc;
    logic [IMM_W-1:0] imm;
    logic             is_branch;
    logic             redirect;
    logic             hold;
    logic             squash;
    wen_t             wen;

    bfc_decode u_dec (
        .instr     (dec_instr),
        .squash    (squash),
        .is_branch (is_branch),
        .wen       (wen),
        .imm       (imm),
        .issued    (iss_instr)
    );

    bfc_target #(.XLEN(XLEN)) u_tgt (
        .br_pc  (dec_pc_q),
        .imm    (imm),
        .target (target)
    );

    bfc_resolve #(.XLEN(XLEN), .EARLY(EARLY_RESOLVE)) u_res (
        .clk         (clk),
        .rst         (rst),
        .is_branch   (is_branch),
        .opnd_a      (dec_rs_val),
        .opnd_b      (dec_rt_val),
        .target      (target),
        .redirect    (redirect),
        .redirect_pc (redirect_pc),
        .hold        (hold),
        .squash      (squash)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            dec_pc_q <= '0;
        end else begin
            if (!hold)
                dec_pc_q <= pc_q;
            if (redirect)
                pc_q <= redirect_pc;
            else if (!hold)
                pc_q <= pc_q + PC_STEP;
        end
    end

    assign fetch_pc   = pc_q;
    assign fetch_hold = hold;
    assign dec_squash = squash;
    assign iss_reg_we = wen.reg_we;
    assign iss_mem_we = wen.mem_we;
endmodule

// File: rtl/bfc_checker.sv
module bfc_checker
    import bfc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter bit EARLY = 1'b1
) (
    input logic               clk,
    input logic               rst,
    input logic [XLEN-1:0]    fetch_pc,
    input logic               fetch_hold,
    input logic               dec_squash,
    input logic [INSTR_W-1:0] iss_instr,
    input logic               iss_reg_we,
    input logic               iss_mem_we,
    input logic               redirect
);
    logic rst_q;
    logic live;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        live  <= !rst;
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        (rst_q && !rst) |-> (fetch_pc == '0 && !dec_squash)); // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (live && !$past(fetch_hold) && !$past(redirect))
            |-> (fetch_pc == $past(fetch_pc) + XLEN'(STEP_B))); // R2

    AST_BUBBLE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        dec_squash |-> (iss_instr == '0 && !iss_reg_we && !iss_mem_we)); // R8

    AST_BRANCH_SILENT: assert property (@(posedge clk) disable iff (rst)
        (iss_instr[INSTR_W-1 -: OPC_W] == OPC_BEQ) |-> (!iss_reg_we && !iss_mem_we)); // R9

    generate
        if (EARLY) begin : g_early_chk
            AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (rst)
                (live && $past(redirect)) |-> dec_squash); // R4
            AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (rst)
                dec_squash |=> !dec_squash); // R4
            AST_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
                !fetch_hold); // R4
        end else begin : g_late_chk
            AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (rst)
                (live && fetch_hold && !$past(fetch_hold)) |=> fetch_hold); // R6
            AST_HOLD_END: assert property (@(posedge clk) disable iff (rst)
                (live && fetch_hold && $past(fetch_hold)) |=> (!fetch_hold && dec_squash)); // R6
        end
    endgenerate
endmodule

bind branch_fetch_ctrl bfc_checker #(.XLEN(XLEN), .EARLY(EARLY_RESOLVE)) u_bfc_chk (
    .clk        (clk),
    .rst        (rst),
    .fetch_pc   (fetch_pc),
    .fetch_hold (fetch_hold),
    .dec_squash (dec_squash),
    .iss_instr  (iss_instr),
    .iss_reg_we (iss_reg_we),
    .iss_mem_we (iss_mem_we),
    .redirect   (redirect)
);

// File: tb/branch_fetch_ctrl_bench.sv
module branch_fetch_ctrl_bench;
    import bfc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_CYC      = 6;
    localparam int N_VEC      = 7;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] imm;
        logic        tk;
    } vec_t;

    localparam vec_t VECS [N_VEC] = '{
        '{32'd5,          32'd5,          16'd5,      1'b1},
        '{32'd5,          32'd6,          16'd5,      1'b0},
        '{32'hFFFF_FFFF,  32'hFFFF_FFFF,  16'hFFFF,   1'b1},
        '{32'h8000_0000,  32'd0,          16'h0003,   1'b0},
        '{32'd0,          32'd0,          16'h0000,   1'b1},
        '{32'hDEAD_BEEF,  32'hDEAD_BEEF,  16'h8000,   1'b1},
        '{32'h0000_1234,  32'h0000_1235,  16'h7FFF,   1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] id_e = '0;
    logic [31:0] id_b = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;

    logic [31:0] pc_e, pc_b, is_e, is_b;
    logic        hd_e, hd_b, sq_e, sq_b, rw_e, rw_b, mw_e, mw_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_fetch_ctrl #(.XLEN(32), .EARLY_RESOLVE(1'b1)) u_branch_fetch_ctrl (
        .clk(clk), .rst(rst), .dec_instr(id_e), .dec_rs_val(opa), .dec_rt_val(opb),
        .fetch_pc(pc_e), .fetch_hold(hd_e), .dec_squash(sq_e),
        .iss_instr(is_e), .iss_reg_we(rw_e), .iss_mem_we(mw_e));

    branch_fetch_ctrl #(.XLEN(32), .EARLY_RESOLVE(1'b0)) u_branch_fetch_ctrl_base (
        .clk(clk), .rst(rst), .dec_instr(id_b), .dec_rs_val(opa), .dec_rt_val(opb),
        .fetch_pc(pc_b), .fetch_hold(hd_b), .dec_squash(sq_b),
        .iss_instr(is_b), .iss_reg_we(rw_b), .iss_mem_we(mw_b));

    int          n_chk = 0;
    int          n_bad = 0;
    int          prog_sel = 0;
    logic [15:0] br_imm = '0;

    logic [31:0] o_pc_e [N_CYC];
    logic [31:0] o_is_e [N_CYC];
    logic        o_hd_e [N_CYC];
    logic        o_sq_e [N_CYC];
    logic        o_rw_e [N_CYC];
    logic        o_mw_e [N_CYC];
    logic [31:0] o_pc_b [N_CYC];
    logic [31:0] o_is_b [N_CYC];
    logic        o_hd_b [N_CYC];
    logic        o_sq_b [N_CYC];
    logic        o_rw_b [N_CYC];
    logic        o_mw_b [N_CYC];

    function automatic logic [31:0] w_beq(input logic [15:0] imm);
        return {6'b000100, 5'd1, 5'd2, imm};
    endfunction

    // every filler word carries its own address in the immediate field
    function automatic logic [31:0] w_alu(input logic [31:0] a);
        return {6'b001000, 5'd0, 5'd3, a[15:0]};
    endfunction

    function automatic logic [31:0] imem(input logic [31:0] a);
        if (prog_sel == 3 && a == 32'd0) return {6'b101011, 5'd0, 5'd3, 16'h0};
        if (a == 32'd4) return (prog_sel == 2) ? {6'b000101, 5'd1, 5'd2, br_imm} : w_beq(br_imm);
        if (prog_sel == 1 && a == 32'd8) return w_beq(16'd100);
        return w_alu(a);
    endfunction

    // branch at address 4: target = 4 + 4 + sext(imm) * 4 (R3)
    function automatic logic [31:0] tgt_of(input logic [15:0] imm);
        return 32'd8 + {{14{imm[15]}}, imm, 2'b00};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sample(input int c);
        o_pc_e[c] = pc_e; o_is_e[c] = is_e; o_hd_e[c] = hd_e; o_sq_e[c] = sq_e;
        o_rw_e[c] = rw_e; o_mw_e[c] = mw_e;
        o_pc_b[c] = pc_b; o_is_b[c] = is_b; o_hd_b[c] = hd_b; o_sq_b[c] = sq_b;
        o_rw_b[c] = rw_b; o_mw_b[c] = mw_b;
    endtask

    task automatic reset_duts();
        rst = 1'b1; id_e = '0; id_b = '0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        #2;
    endtask

    // models the decode register of the surrounding pipeline
    task automatic tick();
        logic [31:0] pe, pb;
        logic        he, hb;
        @(negedge clk);
        pe = pc_e; he = hd_e; pb = pc_b; hb = hd_b;
        @(posedge clk);
        #1;
        if (!he) id_e = imem(pe);
        if (!hb) id_b = imem(pb);
        #2;
    endtask

    task automatic run_prog();
        reset_duts();
        sample(0);
        for (int c = 1; c < N_CYC; c++) begin
            tick();
            sample(c);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int v = 0; v < N_VEC; v++) begin
            logic [31:0] t;
            logic        tk;
            opa = VECS[v].a; opb = VECS[v].b; br_imm = VECS[v].imm; tk = VECS[v].tk;
            prog_sel = 0;
            t = tgt_of(br_imm);
            run_prog();

            // R1 reset state, both schemes
            chk(o_pc_e[0] == 0 && !o_sq_e[0] && !o_hd_e[0], "R1 early reset", o_pc_e[0], 0);
            chk(o_pc_b[0] == 0 && !o_sq_b[0] && !o_hd_b[0], "R1 base reset", o_pc_b[0], 0);
            // R2 sequential stepping, R9 ALU enables
            chk(o_pc_e[1] == 4 && o_is_e[1] == imem(0), "R2 early step", o_pc_e[1], 4);
            chk(o_rw_e[1] && !o_mw_e[1], "R9 alu enables", {o_rw_e[1], o_mw_e[1]}, 2'b10);

            // early scheme
            chk(o_is_e[2] == w_beq(br_imm) && !o_rw_e[2] && !o_mw_e[2], "R9 branch silent early", o_is_e[2], w_beq(br_imm));
            chk(!o_hd_e[2] && !o_hd_e[3], "R4 early no hold", {o_hd_e[2], o_hd_e[3]}, 0);
            if (tk) begin
                chk(o_pc_e[3] == t, "R3 R4 early target", o_pc_e[3], t);
                chk(o_sq_e[3] && o_is_e[3] == 0 && !o_rw_e[3] && !o_mw_e[3], "R4 R8 early bubble", o_is_e[3], 0);
                chk(!o_sq_e[4] && o_is_e[4] == imem(t), "R4 early resume", o_is_e[4], imem(t));
                chk(o_pc_e[4] == t + 4, "R4 early pc after", o_pc_e[4], t + 4);
            end else begin
                chk(o_pc_e[3] == 12 && !o_sq_e[3], "R5 early fallthrough", o_pc_e[3], 12);
                chk(o_is_e[3] == imem(8) && o_rw_e[3], "R5 early next issued", o_is_e[3], imem(8));
                chk(o_is_e[4] == imem(12) && o_pc_e[4] == 16, "R5 early stream", o_is_e[4], imem(12));
            end

            // baseline scheme
            chk(o_hd_b[2] && o_pc_b[2] == 8, "R6 base hold first", {o_hd_b[2], o_pc_b[2][30:0]}, {1'b1, 31'd8});
            chk(o_is_b[2] == w_beq(br_imm) && !o_rw_b[2] && !o_mw_b[2], "R9 branch silent base", o_is_b[2], w_beq(br_imm));
            chk(o_hd_b[3] && o_sq_b[3] && o_pc_b[3] == 8, "R6 base hold second", o_pc_b[3], 8);
            chk(o_is_b[3] == 0 && !o_rw_b[3] && !o_mw_b[3], "R8 base bubble", o_is_b[3], 0);
            chk(!o_hd_b[4] && o_sq_b[4] && o_is_b[4] == 0, "R6 base second bubble", o_is_b[4], 0);
            chk(o_pc_b[4] == (tk ? t : 32'd8), "R3 R7 base resolve pc", o_pc_b[4], tk ? t : 32'd8);
            chk(!o_sq_b[5] && o_is_b[5] == imem(tk ? t : 32'd8), "R6 base resume", o_is_b[5], imem(tk ? t : 32'd8));
            chk(o_pc_b[5] == (tk ? t + 4 : 32'd12), "R7 base pc after", o_pc_b[5], tk ? t + 4 : 32'd12);
        end

        // R10: wrong-path branch in the squashed slot must not redirect
        opa = 32'd7; opb = 32'd7; br_imm = 16'd5; prog_sel = 1;
        run_prog();
        chk(o_sq_e[3] && o_is_e[3] == 0, "R10 squashed slot bubble", o_is_e[3], 0);
        chk(o_pc_e[4] == 32'd32, "R10 squashed branch ignored", o_pc_e[4], 32'd32);
        chk(o_is_e[4] == w_alu(32'd28), "R10 target issued", o_is_e[4], w_alu(32'd28));

        // R2: a near-miss opcode with equal operands is not a branch
        prog_sel = 2;
        run_prog();
        chk(o_pc_e[3] == 12 && !o_sq_e[3], "R2 other opcode early", o_pc_e[3], 12);
        chk(!o_hd_b[2] && o_pc_b[3] == 12 && !o_sq_b[3], "R2 other opcode base", o_pc_b[3], 12);

        // R9: store enables
        prog_sel = 3;
        run_prog();
        chk(!o_rw_e[1] && o_mw_e[1], "R9 store early", {o_rw_e[1], o_mw_e[1]}, 2'b01);
        chk(!o_rw_b[1] && o_mw_b[1], "R9 store base", {o_rw_b[1], o_mw_b[1]}, 2'b01);

        // R1: reset in the middle of a bubble / stall clears it
        prog_sel = 0; opa = 32'd1; opb = 32'd1; br_imm = 16'd5;
        reset_duts();
        tick(); tick(); tick();
        chk(sq_e && hd_b, "R1 pending before reset", {sq_e, hd_b}, 2'b11);
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0; id_e = '0; id_b = '0;
        #2;
        chk(pc_e == 0 && !sq_e && !hd_e, "R1 early cleared", pc_e, 0);
        chk(pc_b == 0 && !sq_b && !hd_b, "R1 base cleared", {pc_b[30:0], sq_b}, 0);
        tick();
        chk(pc_e == 4 && pc_b == 4 && !sq_b, "R1 R2 restart", pc_b, 4);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule